// File: doc/BRIEF.md
# Corrected-Record Readout Handshake Controller

This block hands a host processor one 36-byte record for each transfer request over an 8-bit parallel port. An upstream corrector pulses `rec_strobe` when it starts to refill the record buffer. The block waits out a fixed buffer-write window and then drops the interrupt line. From that point the record can be read byte by byte for a limited time. Bytes 0 and 1 are status that the block builds from fields captured at the strobe. Bytes 2 to 35 come from a 34-entry buffer through a synchronous read port with one cycle of latency (`buf_addr` out, `buf_rdata` back on the next cycle).

The byte handshake works as a valid/ready pair that the host paces. The host asks for a byte by pulling `re_n` low. `rdy` dips low for a fixed number of cycles while the byte is fetched. After that `byte_ok_n` goes low and the byte sits on `dat`. The host applies back-pressure simply by keeping `re_n` low: the byte stays put until `re_n` rises, and the rise advances the pointer. Record lifetime is set by timers, not by host acknowledgement. It is shorter for vertically corrected records than for horizontal-only ones. `avail_n` marks a shorter guaranteed-transfer span for hosts that poll instead of taking the interrupt.

For vertically corrected records the block also numbers the data block that the buffer must supply. Numbering restarts at each frame, runs up to the last data block, and can be made to jump forward by a skip request.

Top module: `rr_readout_ctrl`

## Requirements
- R1: During and right after reset, `intr_n`, `rdy`, `byte_ok_n` and `avail_n` are 1 and `dat` is 0.
- R2: `intr_n` falls exactly `WR_CYC` cycles after the clock edge that samples `rec_strobe`. A read started inside that write window gets no `rdy` dip and no data, and it does not move the byte pointer.
- R3: When `re_n` falls during a live record, `rdy` is low for exactly `DIP_CYC` cycles. On the next cycle `byte_ok_n` goes low with the byte on `dat`, and both hold while `re_n` stays low. When `re_n` rises, `byte_ok_n` returns to 1, `dat` returns to 0 and the pointer advances by one.
- R4: Byte 0 is the block number. Byte 1 is a flag byte: bit0 parity block, bit1 correction OK, bit2 block sync, bit3 frame sync, bit4 vertical record, bits 7:5 zero. Byte k for k from 2 to 35 is the buffer word at address k-2.
- R5: Once all 36 bytes have been read, any further read of the same record gets no dip and no data.
- R6: `avail_n` goes low on the same cycle as the interrupt edge and stays low for exactly `AVAIL_CYC` cycles.
- R7: A record stays readable for `WIN_V_CYC` cycles after its interrupt edge if it is vertical and for `WIN_H_CYC` cycles if it is horizontal. When the window ends, a byte on show is withdrawn on that same cycle, and later reads get nothing.
- R8: `intr_n` returns high at the first `re_n` fall of the record, or when the window ends if no read came.
- R9: Each new record restarts the byte pointer at byte 0, even if the previous record was abandoned partway through.
- R10: The first vertical record after `frame_start` is numbered 0. Each later vertical record is numbered one higher, and the number wraps from `LAST_BLK` (189) back to 0. `vblk_sel` shows the current number. Horizontal records carry `st_blk` in byte 0 and leave the numbering alone.
- R11: A `skip_wr` value up to `LAST_BLK` becomes the number of the next vertical record. If `skip_wr` arrives on the same cycle as a vertical strobe, it applies to the vertical record after that one. Values above `LAST_BLK` are ignored.
- R12: If `re_n` rises during the `rdy` dip, the read is cancelled: `rdy` returns high, no byte is shown and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_strobe | input | 1 | One-cycle pulse: buffer refill for a new record begins |
| rec_vert | input | 1 | Record kind at the strobe: 1 vertical, 0 horizontal |
| st_blk | input | BLK_W | Block number for horizontal records |
| st_parity | input | 1 | Record is a parity block |
| st_corr_ok | input | 1 | Correction succeeded |
| st_blk_sync | input | 1 | Block sync held |
| st_frm_sync | input | 1 | Frame sync held |
| frame_start | input | 1 | Restart vertical numbering |
| skip_wr | input | 1 | Load a skip target |
| skip_blk | input | BLK_W | Skip target block number |
| vblk_sel | output | BLK_W | Block number of the current vertical record |
| buf_addr | output | 6 | Buffer read address |
| buf_rdata | input | 8 | Buffer read data, one cycle after address |
| re_n | input | 1 | Host read request, active low |
| rdy | output | 1 | Pacing flag, dips low during a fetch |
| byte_ok_n | output | 1 | Low while a valid byte is on `dat` |
| dat | output | 8 | Record byte, 0 when no byte is shown |
| intr_n | output | 1 | Interrupt, falls when a record becomes readable |
| avail_n | output | 1 | Low during the guaranteed-transfer span |

## Verification
Full 36-byte reads of horizontal records separate the status bytes from buffer bytes and expose any offset in the address mapping. Reads timed inside the write window, past the end of the record, straddling window expiry and cancelled inside the dip show whether the pointer and the output gating react only when they should. Vertical sequences with frame restarts, in-range and out-of-range skips, a skip on the same cycle as a strobe and the 189-to-0 wrap check the numbering order. A seeded random mix of record kinds, flag values, partial read lengths and gaps between reads then confirms that every record restarts at byte 0.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int REC_BYTES  = 36;
  localparam int STAT_BYTES = 2;
  localparam int DATA_BYTES = REC_BYTES - STAT_BYTES;

  typedef enum logic [1:0] {LT_IDLE, LT_WRITE, LT_LIVE} life_st_t;
  typedef enum logic [1:0] {BP_IDLE, BP_DIP, BP_SHOW, BP_WAIT} port_st_t;

  typedef struct packed {
    logic [2:0] rsv;
    logic       vert;
    logic       frm_sync;
    logic       blk_sync;
    logic       corr_ok;
    logic       parity;
  } flag_byte_t;
endpackage

// File: rtl/rr_life_timer.sv
module rr_life_timer
  import rr_pkg::*;
#(
  parameter int WR_CYC    = 245,
  parameter int AVAIL_CYC = 21600,
  parameter int WIN_V_CYC = 32400,
  parameter int WIN_H_CYC = 64800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rec_strobe,
  input  logic rec_vert,
  input  logic re_fall,
  output logic rec_live,
  output logic new_rec,
  output logic intr_n,
  output logic avail_n
);
  localparam int WMAX = (WIN_H_CYC > WIN_V_CYC) ? WIN_H_CYC : WIN_V_CYC;
  localparam int AMAX = (AVAIL_CYC > WR_CYC) ? AVAIL_CYC : WR_CYC;
  localparam int LIM  = (WMAX > AMAX) ? WMAX : AMAX;
  localparam int TW   = $clog2(LIM + 1);

  life_st_t        st;
  logic [TW-1:0]   cnt;
  logic [TW-1:0]   last_cnt;
  logic            vert_q;
  logic            intr_low;

  // window length picked by the record kind latched at the strobe
  assign last_cnt = vert_q ? TW'(WIN_V_CYC - 1) : TW'(WIN_H_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= LT_IDLE;
      cnt      <= '0;
      vert_q   <= 1'b0;
      intr_low <= 1'b0;
    end else if (rec_strobe) begin
      st       <= LT_WRITE;
      cnt      <= TW'(WR_CYC - 1);
      vert_q   <= rec_vert;
      intr_low <= 1'b0;
    end else begin
      case (st)
        LT_WRITE: begin
          if (cnt == '0) begin
            st       <= LT_LIVE;
            intr_low <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        LT_LIVE: begin
          if (cnt == last_cnt) begin
            st       <= LT_IDLE;
            cnt      <= '0;
            intr_low <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
            if (re_fall) intr_low <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign rec_live = (st == LT_LIVE);
  assign new_rec  = (st == LT_WRITE) && (cnt == '0) && !rec_strobe;
  assign intr_n   = !intr_low;
  assign avail_n  = !(rec_live && (cnt < TW'(AVAIL_CYC)));

  // R2
  intr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intr_n) |-> rec_live);
  // R6
  avail_with_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(avail_n) |-> $fell(intr_n));
  // R8
  intr_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_live) |-> !intr_n);
endmodule

// File: rtl/rr_vert_seq.sv
module rr_vert_seq #(
  parameter int BLK_W    = 8,
  parameter int LAST_BLK = 189
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             vert_req,
  input  logic             skip_wr,
  input  logic [BLK_W-1:0] skip_blk,
  output logic [BLK_W-1:0] vblk_next,
  output logic [BLK_W-1:0] vblk
);
  localparam logic [BLK_W-1:0] LASTV = BLK_W'(LAST_BLK);

  logic             started;
  logic             pend;
  logic [BLK_W-1:0] pval;
  logic             skip_ok;

  assign skip_ok = skip_wr && (skip_blk <= LASTV);

  always_comb begin
    if (pend)             vblk_next = pval;
    else if (!started)    vblk_next = '0;
    else if (vblk == LASTV) vblk_next = '0;
    else                  vblk_next = vblk + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblk    <= '0;
      started <= 1'b0;
      pend    <= 1'b0;
      pval    <= '0;
    end else begin
      if (vert_req) begin
        vblk    <= vblk_next;
        started <= 1'b1;
        pend    <= 1'b0;
      end
      // a skip landing with a request waits for the following one
      if (skip_ok) begin
        pend <= 1'b1;
        pval <= skip_blk;
      end
      if (frame_start) started <= 1'b0;
    end
  end

  // R10
  vblk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblk <= LASTV);
  // R10
  vblk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vert_req && !pend && started && !frame_start && vblk != LASTV) |=> vblk == $past(vblk) + 1'b1);
  // R11
  skip_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vert_req && pend) |=> vblk == $past(pval));
endmodule

// File: rtl/rr_byte_port.sv
module rr_byte_port
  import rr_pkg::*;
#(
  parameter int DIP_CYC = 8,
  parameter int AW      = $clog2(DATA_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re_n,
  input  logic          rec_live,
  input  logic          new_rec,
  input  logic          cap_en,
  input  logic [7:0]    cap_b0,
  input  logic [7:0]    cap_b1,
  input  logic [7:0]    buf_rdata,
  output logic [AW-1:0] buf_addr,
  output logic          re_fall,
  output logic          rdy,
  output logic          byte_ok_n,
  output logic [7:0]    dat
);
  localparam int PW = $clog2(REC_BYTES + 1);
  localparam int DW = $clog2(DIP_CYC + 1);

  port_st_t      ps;
  logic [PW-1:0] ptr;
  logic [DW-1:0] dcnt;
  logic          re_q;
  logic [7:0]    b0_q, b1_q, dq, pick;
  logic          showing;

  assign re_fall  = re_q && !re_n;
  assign buf_addr = (ptr >= PW'(STAT_BYTES)) ? AW'(ptr - PW'(STAT_BYTES)) : '0;

  always_comb begin
    if (ptr == PW'(0))      pick = b0_q;
    else if (ptr == PW'(1)) pick = b1_q;
    else                    pick = buf_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps   <= BP_IDLE;
      ptr  <= '0;
      dcnt <= '0;
      re_q <= 1'b1;
      b0_q <= '0;
      b1_q <= '0;
      dq   <= '0;
    end else begin
      re_q <= re_n;
      if (cap_en) begin
        b0_q <= cap_b0;
        b1_q <= cap_b1;
      end
      if (new_rec) ptr <= '0;
      case (ps)
        BP_IDLE: begin
          if (re_fall) begin
            if (rec_live && ptr < PW'(REC_BYTES)) begin
              ps   <= BP_DIP;
              dcnt <= DW'(DIP_CYC - 1);
            end else begin
              ps <= BP_WAIT;
            end
          end
        end
        BP_DIP: begin
          if (!rec_live)       ps <= BP_WAIT;
          else if (re_n)       ps <= BP_IDLE;
          else if (dcnt == '0) begin
            ps <= BP_SHOW;
            dq <= pick;
          end else             dcnt <= dcnt - 1'b1;
        end
        BP_SHOW: begin
          if (!rec_live) ps <= BP_WAIT;
          else if (re_n) begin
            ps  <= BP_IDLE;
            ptr <= ptr + 1'b1;
          end
        end
        default: begin
          if (re_n) ps <= BP_IDLE;
        end
      endcase
    end
  end

  assign showing   = (ps == BP_SHOW) && rec_live;
  assign rdy       = (ps != BP_DIP);
  assign byte_ok_n = !showing;
  assign dat       = showing ? dq : 8'h00;

  // R3
  show_after_dip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byte_ok_n) |-> $past(!rdy));
  // R5
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(REC_BYTES));
  // R12
  dip_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && re_n && rec_live) |=> rdy && byte_ok_n);
endmodule

// File: rtl/rr_readout_ctrl.sv
module rr_readout_ctrl
  import rr_pkg::*;
#(
  parameter int BLK_W     = 8,
  parameter int LAST_BLK  = 189,
  parameter int DIP_CYC   = 8,
  parameter int WR_CYC    = 245,
  parameter int AVAIL_CYC = 21600,
  parameter int WIN_V_CYC = 32400,
  parameter int WIN_H_CYC = 64800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_strobe,
  input  logic             rec_vert,
  input  logic [BLK_W-1:0] st_blk,
  input  logic             st_parity,
  input  logic             st_corr_ok,
  input  logic             st_blk_sync,
  input  logic             st_frm_sync,
  input  logic             frame_start,
  input  logic             skip_wr,
  input  logic [BLK_W-1:0] skip_blk,
  output logic [BLK_W-1:0] vblk_sel,
  output logic [5:0]       buf_addr,
  input  logic [7:0]       buf_rdata,
  input  logic             re_n,
  output logic             rdy,
  output logic             byte_ok_n,
  output logic [7:0]       dat,
  output logic             intr_n,
  output logic             avail_n
);
  logic             rec_live, new_rec, re_fall;
  logic [BLK_W-1:0] vblk_next;
  logic [7:0]       cap_b0;
  flag_byte_t       cap_b1;

  assign cap_b0 = 8'(rec_vert ? vblk_next : st_blk);
  always_comb begin
    cap_b1          = '0;
    cap_b1.parity   = st_parity;
    cap_b1.corr_ok  = st_corr_ok;
    cap_b1.blk_sync = st_blk_sync;
    cap_b1.frm_sync = st_frm_sync;
    cap_b1.vert     = rec_vert;
  end

  rr_life_timer #(
    .WR_CYC(WR_CYC), .AVAIL_CYC(AVAIL_CYC),
    .WIN_V_CYC(WIN_V_CYC), .WIN_H_CYC(WIN_H_CYC)
  ) u_life (
    .clk(clk), .rst_n(rst_n), .rec_strobe(rec_strobe), .rec_vert(rec_vert),
    .re_fall(re_fall), .rec_live(rec_live), .new_rec(new_rec),
    .intr_n(intr_n), .avail_n(avail_n)
  );

  rr_vert_seq #(.BLK_W(BLK_W), .LAST_BLK(LAST_BLK)) u_vseq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .vert_req(rec_strobe && rec_vert), .skip_wr(skip_wr), .skip_blk(skip_blk),
    .vblk_next(vblk_next), .vblk(vblk_sel)
  );

  rr_byte_port #(.DIP_CYC(DIP_CYC), .AW(6)) u_port (
    .clk(clk), .rst_n(rst_n), .re_n(re_n), .rec_live(rec_live),
    .new_rec(new_rec), .cap_en(rec_strobe), .cap_b0(cap_b0), .cap_b1(cap_b1),
    .buf_rdata(buf_rdata), .buf_addr(buf_addr), .re_fall(re_fall),
    .rdy(rdy), .byte_ok_n(byte_ok_n), .dat(dat)
  );
endmodule

// File: tb/tb_rr_readout_ctrl.sv
module tb_rr_readout_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIP = 4, WR = 10, AV = 200, WV = 400, WH = 800;

  logic clk = 0, rst_n = 0;
  logic rec_strobe = 0, rec_vert = 0, frame_start = 0, skip_wr = 0, re_n = 1;
  logic st_parity = 0, st_corr_ok = 0, st_blk_sync = 0, st_frm_sync = 0;
  logic [7:0] st_blk = 0, skip_blk = 0, vblk_sel, dat, buf_rdata = 0, salt = 0;
  logic [5:0] buf_addr;
  logic rdy, byte_ok_n, intr_n, avail_n;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [7:0] exp_b0, exp_b1, cur_salt;
  bit mstarted = 0, mpend = 0;
  int mpval = 0, mvb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_readout_ctrl #(.DIP_CYC(DIP), .WR_CYC(WR), .AVAIL_CYC(AV),
    .WIN_V_CYC(WV), .WIN_H_CYC(WH)) dut (
    .clk(clk), .rst_n(rst_n), .rec_strobe(rec_strobe), .rec_vert(rec_vert),
    .st_blk(st_blk), .st_parity(st_parity), .st_corr_ok(st_corr_ok),
    .st_blk_sync(st_blk_sync), .st_frm_sync(st_frm_sync),
    .frame_start(frame_start), .skip_wr(skip_wr), .skip_blk(skip_blk),
    .vblk_sel(vblk_sel), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .re_n(re_n), .rdy(rdy), .byte_ok_n(byte_ok_n), .dat(dat),
    .intr_n(intr_n), .avail_n(avail_n));

  function automatic logic [7:0] bfun(int a, logic [7:0] s);
    return {a[5:0], 2'b00} ^ s;
  endfunction

  function automatic logic [7:0] expbyte(int idx);
    if (idx == 0) return exp_b0;
    if (idx == 1) return exp_b1;
    return bfun(idx - 2, cur_salt);
  endfunction

  always_ff @(posedge clk) buf_rdata <= bfun(int'(buf_addr), salt);

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
      summary();
    end
  end

  task automatic chk_eq(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic read_one(output bit ok, output logic [7:0] v, output int dips);
    re_n = 0; dips = 0;
    for (int i = 0; i < DIP + 3; i++) begin
      @(negedge clk);
      if (!rdy) dips++;
      if (!byte_ok_n) break;
    end
    ok = !byte_ok_n; v = dat; re_n = 1;
    @(negedge clk);
  endtask

  task automatic read_chk(int idx, string tag);
    bit ok; logic [7:0] v; int d;
    read_one(ok, v, d);
    chk_eq({tag, " byte shown"}, ok, 1);
    chk_eq({tag, " dip length"}, d, DIP);
    chk_eq({tag, " byte value"}, v, expbyte(idx));
  endtask

  task automatic read_none(string tag);
    bit ok; logic [7:0] v; int d;
    read_one(ok, v, d);
    chk_eq({tag, " no byte"}, ok, 0);
    chk_eq({tag, " no dip"}, d, 0);
  endtask

  task automatic do_skip(int v);
    skip_blk = 8'(v); skip_wr = 1;
    @(negedge clk); skip_wr = 0;
    if (v <= 189) begin mpend = 1; mpval = v; end
  endtask

  task automatic do_frame();
    frame_start = 1; @(negedge clk); frame_start = 0; mstarted = 0;
  endtask

  task automatic start_rec(bit vert, int blk, logic [3:0] fl, int sk, bit probe);
    if (vert) begin
      if (mpend) begin mvb = mpval; mpend = 0; end
      else if (!mstarted) mvb = 0;
      else mvb = (mvb == 189) ? 0 : mvb + 1;
      mstarted = 1; exp_b0 = 8'(mvb);
    end else exp_b0 = 8'(blk);
    if (sk >= 0 && sk <= 189) begin mpend = 1; mpval = sk; end
    exp_b1 = {3'b000, vert, fl};
    cur_salt = 8'($urandom);
    rec_vert = vert; st_blk = 8'(blk);
    {st_frm_sync, st_blk_sync, st_corr_ok, st_parity} = fl;
    if (sk >= 0) begin skip_wr = 1; skip_blk = 8'(sk); end
    salt = cur_salt; rec_strobe = 1;
    @(negedge clk);
    rec_strobe = 0; skip_wr = 0;
    if (probe) begin
      read_none("R2 read in write window");
      repeat (WR - 1 - (DIP + 4)) @(negedge clk);
    end else repeat (WR - 1) @(negedge clk);
    chk_eq("R2 intr still high", intr_n, 1);
    @(negedge clk);
    chk_eq("R2 intr edge", intr_n, 0);
    if (vert) chk_eq("R10 vblk_sel", vblk_sel, mvb);
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd777));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk_eq("R1 intr_n in reset", intr_n, 1);
    chk_eq("R1 rdy in reset", rdy, 1);
    rst_n = 1;
    @(negedge clk);
    chk_eq("R1 intr_n", intr_n, 1);
    chk_eq("R1 rdy", rdy, 1);
    chk_eq("R1 byte_ok_n", byte_ok_n, 1);
    chk_eq("R1 avail_n", avail_n, 1);
    chk_eq("R1 dat", dat, 0);

    // full horizontal record: timing, order, exhaustion
    start_rec(0, 8'h55, 4'b1011, -1, 0);
    cnt = 0;
    while (!avail_n && cnt < AV + 5) begin cnt++; @(negedge clk); end
    chk_eq("R6 avail span", cnt, AV);
    chk_eq("R8 intr held until read", intr_n, 0);
    read_chk(0, "R4 status byte 0");
    chk_eq("R8 intr released by read", intr_n, 1);
    chk_eq("R3 byte_ok_n after release", byte_ok_n, 1);
    chk_eq("R3 dat after release", dat, 0);
    for (int i = 1; i < 36; i++) read_chk(i, "R4 full read");
    read_none("R5 past last byte");

    // read inside the write window
    start_rec(0, 8'h21, 4'b0110, -1, 1);
    read_chk(0, "R2 pointer untouched");

    // vertical numbering and skip
    do_frame();
    start_rec(1, 0, 4'b1110, -1, 0); read_chk(0, "R10 first vertical");
    start_rec(1, 0, 4'b1110, -1, 0); read_chk(0, "R10 step");
    do_skip(187);
    start_rec(1, 0, 4'b1111, -1, 0); read_chk(0, "R11 skip taken");
    start_rec(1, 0, 4'b1111, -1, 0); read_chk(0, "R10 after skip");
    start_rec(1, 0, 4'b1111, -1, 0); read_chk(0, "R10 last block");
    start_rec(1, 0, 4'b1111, -1, 0); read_chk(0, "R10 wrap");
    do_skip(200);
    start_rec(1, 0, 4'b1111, -1, 0); read_chk(0, "R11 big skip ignored");
    start_rec(1, 0, 4'b1111, 50, 0); read_chk(0, "R11 same-cycle skip deferred");
    start_rec(0, 8'h99, 4'b0001, -1, 0); read_chk(0, "R10 horizontal keeps st_blk");
    start_rec(1, 0, 4'b1111, -1, 0); read_chk(0, "R11 deferred skip applied");

    // abandon partway, new record restarts
    start_rec(0, 8'h3c, 4'b0101, -1, 0);
    for (int i = 0; i < 5; i++) read_chk(i, "R9 partial");
    start_rec(0, 8'h3d, 4'b0100, -1, 0);
    read_chk(0, "R9 restart at byte 0");
    read_chk(1, "R9 then byte 1");

    // vertical window expiry with no read
    start_rec(1, 0, 4'b1100, -1, 0);
    repeat (WV - 1) @(negedge clk);
    chk_eq("R8 intr low before expiry", intr_n, 0);
    @(negedge clk);
    chk_eq("R8 intr high at expiry", intr_n, 1);
    read_none("R7 after vertical window");

    // horizontal window expiry while a byte is shown
    start_rec(0, 8'h11, 4'b1100, -1, 0);
    repeat (WH - 12) @(negedge clk);
    re_n = 0;
    repeat (8) @(negedge clk);
    chk_eq("R7 shown late in horizontal window", byte_ok_n, 0);
    repeat (3) @(negedge clk);
    chk_eq("R7 shown last live cycle", byte_ok_n, 0);
    @(negedge clk);
    chk_eq("R7 withdrawn at expiry", byte_ok_n, 1);
    chk_eq("R7 dat cleared at expiry", dat, 0);
    re_n = 1; @(negedge clk);
    read_none("R7 after horizontal window");

    // cancel inside the dip
    start_rec(0, 8'h42, 4'b0011, -1, 0);
    re_n = 0; @(negedge clk);
    chk_eq("R12 dip started", rdy, 0);
    re_n = 1; @(negedge clk); @(negedge clk);
    chk_eq("R12 rdy restored", rdy, 1);
    chk_eq("R12 no byte", byte_ok_n, 1);
    read_chk(0, "R12 pointer held");

    // seeded random mix
    for (int r = 0; r < 20; r++) begin
      int nb;
      if ($urandom % 6 == 0) do_frame();
      if ($urandom % 4 == 0) do_skip(int'($urandom % 256));
      start_rec(1'($urandom), int'($urandom % 256), 4'($urandom), -1, 0);
      nb = int'($urandom % 37);
      for (int i = 0; i < nb; i++) begin
        repeat ($urandom % 3) @(negedge clk);
        read_chk(i, "R3 R4 random");
      end
      repeat ($urandom % 5) @(negedge clk);
    end

    done = 1;
    summary();
  end
endmodule